// File: doc/BRIEF.md
# Per-Source Interrupt Coalescing State Table

This block keeps a two-bit coalescing state for each of a configurable number of interrupt sources and decides, event by event, whether an interrupt is forwarded to a downstream router. The high bit marks an event as delivered and awaiting service; the low bit records that another event arrived meanwhile, or, with the high bit clear, that the source is switched off. An end-of-interrupt turns a recorded follow-up event into a fresh delivery instead of dropping it.

Software-side agents reach the table through a single command port that carries a source number and one of four operations: trigger, end-of-interrupt, read, and overwrite. Devices reach it through one level line per source, where a rising edge acts as a trigger. Each command gets a one-cycle response carrying either the state found before the operation or the end-of-interrupt verdict. Every forwarded event leaves the block as a one-cycle pulse tagged with its source number. When several events become due together, they are emitted one per cycle, lowest source first.

Top module: `pq_source_table`

## Requirements
- R1: While reset is asserted and after it is released, rsp_valid and notify_valid are low, and every source holds state 01 (off). A read issued right after reset returns 01 for each source.
- R2: A command is a trigger when cmd_op is 0. It moves state 00 to 10 and forwards an event. It moves 10 and 11 to 11, and leaves 01 at 01, neither forwarding anything. rsp_valid is high exactly one cycle after each command, and for a trigger rsp_data carries the state found before the operation.
- R3: A command is an end-of-interrupt when cmd_op is 1. It moves 00 and 10 to 00 with result 0. It moves 11 to 10 with result 1 and forwards an event. It leaves 01 at 01 with result 0. The response is 2'b00 for result 0 and 2'b01 for result 1.
- R4: A command is a read when cmd_op is 2, and it returns the current state without changing it. A command is an overwrite when cmd_op is 3; it stores cmd_pq and returns the previous state.
- R5: A low-to-high change on src_line[i] applies a trigger to source i. Holding the line high or lowering it changes nothing.
- R6: When a command and a line trigger hit the same source in the same cycle, the command acts first. The line trigger is applied to the resulting state one cycle later.
- R7: Each forwarded event appears as notify_valid high for one cycle, with notify_src naming the source. The earliest pulse comes one cycle after the response of the causing command. When several events are waiting, they leave one per cycle in ascending source order.
- R8: A command whose cmd_src is NUM_SRC or higher changes no state, forwards nothing, and returns 2'b11.
- R9: No forwarded event is lost. Every state change that forwards an event gives exactly one notify pulse, for up to 2^NOTE_CNT_W-1 events outstanding per source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Operation: 0 trigger, 1 end-of-interrupt, 2 read, 3 overwrite |
| cmd_src | input | SRC_W | Target source number |
| cmd_pq | input | 2 | Value stored by an overwrite |
| src_line | input | NUM_SRC | Per-source level lines, rising edge triggers |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 2 | Previous state, end-of-interrupt result, or all ones |
| notify_valid | output | 1 | Forwarded event pulse |
| notify_src | output | SRC_W | Source of the forwarded event |

## Verification
A command sampled on one rising edge has its response registered on that same edge. An event it forwards is counted at that edge and can leave as a notify pulse no earlier than the following edge. A line rise is taken on the edge where it is first seen high, or one edge later when a command on the same source defers it. The bench's reference model steps on every rising edge using exactly these delays and keeps its own per-source counts of waiting events. The outputs are compared on each falling edge, so every result is sampled in the cycle in which it is due.

// File: rtl/pq_tbl_pkg.sv
package pq_tbl_pkg;

   typedef enum logic [1:0] {
      OP_TRIG = 2'd0,
      OP_EOI  = 2'd1,
      OP_GET  = 2'd2,
      OP_SET  = 2'd3
   } pq_op_e;

   localparam logic [1:0] PQ_IDLE   = 2'b00;
   localparam logic [1:0] PQ_OFF    = 2'b01;
   localparam logic [1:0] PQ_PEND   = 2'b10;
   localparam logic [1:0] PQ_QUEUED = 2'b11;

   typedef struct packed {
      logic       fire;
      logic [1:0] nxt;
   } pq_step_t;

   function automatic pq_step_t pq_on_trigger(input logic [1:0] cur);
      pq_step_t s;
      unique case (cur)
         PQ_IDLE:              s = '{fire: 1'b1, nxt: PQ_PEND};
         PQ_PEND, PQ_QUEUED:   s = '{fire: 1'b0, nxt: PQ_QUEUED};
         default:              s = '{fire: 1'b0, nxt: PQ_OFF};
      endcase
      return s;
   endfunction

   function automatic pq_step_t pq_on_eoi(input logic [1:0] cur);
      pq_step_t s;
      unique case (cur)
         PQ_IDLE, PQ_PEND: s = '{fire: 1'b0, nxt: PQ_IDLE};
         PQ_QUEUED:        s = '{fire: 1'b1, nxt: PQ_PEND};
         default:          s = '{fire: 1'b0, nxt: PQ_OFF};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pq_cell.sv
module pq_cell
   import pq_tbl_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_hit,
   input  pq_op_e     cmd_op,
   input  logic [1:0] cmd_pq,
   input  logic       hw_trig,
   input  logic       drain,
   output logic [1:0] state_o,
   output logic       note_pend_o,
   output logic       ovf_o
);

   logic [1:0]       state_q;
   logic [1:0]       state_d;
   logic             fire;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_full;
   pq_step_t         step;

   always_comb begin
      step    = '{fire: 1'b0, nxt: state_q};
      if (cmd_hit) begin
         unique case (cmd_op)
            OP_TRIG: step = pq_on_trigger(state_q);
            OP_EOI:  step = pq_on_eoi(state_q);
            OP_SET:  step = '{fire: 1'b0, nxt: cmd_pq};
            default: step = '{fire: 1'b0, nxt: state_q};
         endcase
      end else if (hw_trig) begin
         step = pq_on_trigger(state_q);
      end
      state_d = step.nxt;
      fire    = step.fire;
   end

   assign cnt_full = &cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PQ_OFF;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         unique case ({fire, drain})
            2'b10:   if (!cnt_full) cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign state_o     = state_q;
   assign note_pend_o = |cnt_q;
   assign ovf_o       = fire & cnt_full & ~drain;

endmodule

// File: rtl/pq_line_gate.sv
module pq_line_gate #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line,
   input  logic [N-1:0] cmd_hit,
   output logic [N-1:0] trig
);

   logic [N-1:0] line_q;
   logic [N-1:0] defer_q;
   logic [N-1:0] want;

   assign want = (line & ~line_q) | defer_q;
   assign trig = want & ~cmd_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         defer_q <= '0;
      end else begin
         line_q  <= line;
         defer_q <= want & cmd_hit;
      end
   end

endmodule

// File: rtl/pq_pick_low.sv
module pq_pick_low #(
   parameter int N     = 6,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/pq_source_table.sv
module pq_source_table
   import pq_tbl_pkg::*;
#(
   parameter int NUM_SRC    = 6,
   parameter int SRC_W      = 4,
   parameter int NOTE_CNT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [SRC_W-1:0]   cmd_src,
   input  logic [1:0]         cmd_pq,
   input  logic [NUM_SRC-1:0] src_line,
   output logic               rsp_valid,
   output logic [1:0]         rsp_data,
   output logic               notify_valid,
   output logic [SRC_W-1:0]   notify_src
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1) begin : g_bad_num_src
      $error("pq_source_table: NUM_SRC must be at least 1");
   end
   if (SRC_W < IDX_W) begin : g_bad_src_w
      $error("pq_source_table: SRC_W too narrow for NUM_SRC");
   end
   if (NOTE_CNT_W < 1) begin : g_bad_cnt_w
      $error("pq_source_table: NOTE_CNT_W must be at least 1");
   end

   pq_op_e                    op;
   logic                      in_range;
   logic [NUM_SRC-1:0]        hit_vec;
   logic [NUM_SRC-1:0]        hw_trig;
   logic [NUM_SRC-1:0]        note_pend;
   logic [NUM_SRC-1:0]        drain;
   logic [NUM_SRC-1:0]        ovf_vec;
   logic [NUM_SRC-1:0][1:0]   st;
   logic [1:0]                sel_state;
   logic [1:0]                rsp_d;
   logic                      pick_any;
   logic [IDX_W-1:0]          pick_idx;
   logic                      note_ovf;
   pq_step_t                  eoi_view;

   logic                      rsp_valid_q;
   logic [1:0]                rsp_data_q;
   logic                      notify_valid_q;
   logic [SRC_W-1:0]          notify_src_q;

   assign op       = pq_op_e'(cmd_op);
   assign in_range = {1'b0, cmd_src} < (SRC_W + 1)'(NUM_SRC);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit_vec[i] = cmd_valid && in_range && (cmd_src == SRC_W'(i));

      pq_cell #(
         .CNT_W (NOTE_CNT_W)
      ) u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .cmd_hit     (hit_vec[i]),
         .cmd_op      (op),
         .cmd_pq      (cmd_pq),
         .hw_trig     (hw_trig[i]),
         .drain       (drain[i]),
         .state_o     (st[i]),
         .note_pend_o (note_pend[i]),
         .ovf_o       (ovf_vec[i])
      );
   end

   pq_line_gate #(
      .N (NUM_SRC)
   ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .line    (src_line),
      .cmd_hit (hit_vec),
      .trig    (hw_trig)
   );

   if (NUM_SRC == 1) begin : g_pick_single
      assign pick_any = note_pend[0];
      assign drain    = note_pend;
      assign pick_idx = '0;
   end else begin : g_pick_multi
      pq_pick_low #(
         .N     (NUM_SRC),
         .IDX_W (IDX_W)
      ) u_pick (
         .req   (note_pend),
         .any   (pick_any),
         .grant (drain),
         .idx   (pick_idx)
      );
   end

   always_comb begin
      sel_state = PQ_OFF;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (hit_vec[i]) sel_state = st[i];
      end
   end

   assign eoi_view = pq_on_eoi(sel_state);

   always_comb begin
      if (!in_range) begin
         rsp_d = 2'b11;
      end else if (op == OP_EOI) begin
         rsp_d = {1'b0, eoi_view.fire};
      end else begin
         rsp_d = sel_state;
      end
   end

   assign note_ovf = |ovf_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q    <= 1'b0;
         rsp_data_q     <= '0;
         notify_valid_q <= 1'b0;
         notify_src_q   <= '0;
      end else begin
         rsp_valid_q    <= cmd_valid;
         rsp_data_q     <= cmd_valid ? rsp_d : 2'b00;
         notify_valid_q <= pick_any;
         notify_src_q   <= pick_any ? SRC_W'(pick_idx) : '0;
      end
   end

   assign rsp_valid    = rsp_valid_q;
   assign rsp_data     = rsp_data_q;
   assign notify_valid = notify_valid_q;
   assign notify_src   = notify_src_q;

endmodule

// File: rtl/pq_source_table_chk.sv
module pq_source_table_chk #(
   parameter int NUM_SRC = 6,
   parameter int SRC_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic [SRC_W-1:0] cmd_src,
   input logic             rsp_valid,
   input logic [1:0]       rsp_data,
   input logic             notify_valid,
   input logic [SRC_W-1:0] notify_src,
   input logic             note_ovf
);

   logic chk_in_range;
   assign chk_in_range = {1'b0, cmd_src} < (SRC_W + 1)'(NUM_SRC);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && !notify_valid));

   p_rsp_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);

   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);

   p_eoi_binary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd1 && chk_in_range) |=> (rsp_data[1] == 1'b0));

   p_note_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
      notify_valid |-> ({1'b0, notify_src} < (SRC_W + 1)'(NUM_SRC)));

   p_oor_all_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !chk_in_range) |=> (rsp_data == 2'b11));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !note_ovf);

endmodule

bind pq_source_table pq_source_table_chk #(
   .NUM_SRC (NUM_SRC),
   .SRC_W   (SRC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_op       (cmd_op),
   .cmd_src      (cmd_src),
   .rsp_valid    (rsp_valid),
   .rsp_data     (rsp_data),
   .notify_valid (notify_valid),
   .notify_src   (notify_src),
   .note_ovf     (note_ovf)
);

// File: tb/test_pq_source_table.sv
module test_pq_source_table;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 6;
   localparam int SW         = 4;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [SW-1:0] cmd_src = '0;
   logic [1:0]    cmd_pq = 2'd0;
   logic [N-1:0]  src_line = '0;
   logic          rsp_valid;
   logic [1:0]    rsp_data;
   logic          notify_valid;
   logic [SW-1:0] notify_src;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string req_tag = "R1";

   pq_source_table #(
      .NUM_SRC    (N),
      .SRC_W      (SW),
      .NOTE_CNT_W (3)
   ) i_pq_source_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_op       (cmd_op),
      .cmd_src      (cmd_src),
      .cmd_pq       (cmd_pq),
      .src_line     (src_line),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .notify_valid (notify_valid),
      .notify_src   (notify_src)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // reference model state
   int m_state [N];
   int m_cnt   [N];
   bit m_defer [N];
   bit m_prev  [N];
   bit exp_rv;
   int exp_rd;
   bit exp_nv;
   int exp_ns;

   function automatic int trig_next(input int s, output bit f);
      f = 0;
      if (s == 0) begin f = 1; return 2; end
      if (s == 1) return 1;
      return 3;
   endfunction

   function automatic int eoi_next(input int s, output bit f);
      f = 0;
      if (s == 3) begin f = 1; return 2; end
      if (s == 1) return 1;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_state[i] = 1; m_cnt[i] = 0; m_defer[i] = 0; m_prev[i] = 0;
         end
         exp_rv = 0; exp_rd = 0; exp_nv = 0; exp_ns = 0;
      end else begin
         bit in_r;
         int src;
         exp_nv = 0; exp_ns = 0;
         for (int i = 0; i < N; i++) begin
            if (!exp_nv && m_cnt[i] > 0) begin
               exp_nv = 1; exp_ns = i; m_cnt[i]--;
            end
         end
         src  = int'(cmd_src);
         in_r = cmd_valid && (src < N);
         exp_rv = cmd_valid;
         exp_rd = 0;
         if (cmd_valid && !in_r) exp_rd = 3;
         for (int i = 0; i < N; i++) begin
            bit want;
            bit f;
            want = (src_line[i] && !m_prev[i]) || m_defer[i];
            f = 0;
            if (in_r && i == src) begin
               int old;
               old = m_state[i];
               case (cmd_op)
                  2'd0: begin m_state[i] = trig_next(old, f); exp_rd = old; end
                  2'd1: begin m_state[i] = eoi_next(old, f); exp_rd = f ? 1 : 0; end
                  2'd2: exp_rd = old;
                  default: begin m_state[i] = int'(cmd_pq); exp_rd = old; end
               endcase
               m_defer[i] = want;
            end else begin
               m_defer[i] = 0;
               if (want) m_state[i] = trig_next(m_state[i], f);
            end
            if (f) m_cnt[i]++;
            m_prev[i] = src_line[i];
         end
      end
   end

   always @(negedge clk) begin
      checks++;
      if (rsp_valid !== exp_rv || (exp_rv && rsp_data !== 2'(exp_rd))) begin
         errors++;
         $display("FAIL %s response: actual v=%0b d=%0d expected v=%0b d=%0d",
                  req_tag, rsp_valid, rsp_data, exp_rv, exp_rd);
      end
      checks++;
      if (notify_valid !== exp_nv || (exp_nv && notify_src !== SW'(exp_ns))) begin
         errors++;
         $display("FAIL %s notify: actual v=%0b s=%0d expected v=%0b s=%0d",
                  req_tag, notify_valid, notify_src, exp_nv, exp_ns);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         errors++;
         $display("FAIL R9 watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(input bit v, input int op, input int src, input int pq,
                       input logic [N-1:0] lines);
      @(negedge clk);
      cmd_valid = v;
      cmd_op    = 2'(op);
      cmd_src   = SW'(src);
      cmd_pq    = 2'(pq);
      src_line  = lines;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, src_line);
   endtask

   initial begin
      logic [15:0] lfsr;
      req_tag = "R1";
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || notify_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset outputs: actual %0b%0b expected 00", rsp_valid, notify_valid);
      end
      rst_n = 1'b1;
      for (int s = 0; s < N; s++) step(1, 2, s, 0, '0);   // R1 reads of 01
      idle(2);

      req_tag = "R2";
      step(1, 0, 2, 0, '0);           // trigger on off state
      req_tag = "R4";
      step(1, 3, 2, 0, '0);           // overwrite to 00
      step(1, 2, 2, 0, '0);
      req_tag = "R2";
      step(1, 0, 2, 0, '0);           // 00 -> 10, forwards
      step(1, 0, 2, 0, '0);           // 10 -> 11
      step(1, 0, 2, 0, '0);           // 11 -> 11
      req_tag = "R3";
      step(1, 1, 2, 0, '0);           // 11 -> 10 result 1
      step(1, 1, 2, 0, '0);           // 10 -> 00 result 0
      step(1, 1, 2, 0, '0);           // 00 -> 00
      step(1, 1, 4, 0, '0);           // 01 stays
      step(1, 2, 4, 0, '0);
      idle(3);

      req_tag = "R4";
      for (int s = 0; s < N; s++) step(1, 3, s, 0, '0);
      req_tag = "R7";
      step(0, 0, 0, 0, 6'b101001);    // R5 rises on 0,3,5 together
      idle(5);
      req_tag = "R5";
      step(0, 0, 0, 0, 6'b101001);    // held high
      step(0, 0, 0, 0, 6'b000000);    // lowered
      for (int s = 0; s < N; s++) step(1, 2, s, 0, '0);
      idle(2);

      req_tag = "R6";
      step(1, 3, 1, 0, '0);
      step(1, 2, 1, 0, 6'b000010);    // read and rise together
      step(1, 2, 1, 0, 6'b000010);
      step(1, 3, 4, 0, 6'b000000);
      step(1, 0, 4, 0, 6'b010000);    // trigger and rise together
      step(1, 2, 4, 0, 6'b010000);
      step(1, 2, 4, 0, 6'b000000);
      idle(3);

      req_tag = "R8";
      step(1, 3, 6, 0, '0);
      step(1, 0, 15, 0, '0);
      step(1, 1, 9, 0, '0);
      for (int s = 0; s < N; s++) step(1, 2, s, 0, '0);
      idle(2);

      req_tag = "R9";
      lfsr = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], int'(lfsr[2:1]), int'(lfsr[6:4]) , int'(lfsr[8:7]) & 2'b10,
              N'(lfsr[14:9]));
      end
      idle(N * 8);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule